// File: doc/BRIEF.md
# AHB Burst Master Sequencer

This block is the bus-side engine of a single AHB-style master. A local client gives it a 3-bit command code, a start address, a base write value and a burst length selector. The block raises a bus request and waits for the arbiter's grant. It then issues one transfer or an incrementing burst, pacing every beat on HREADY, and releases the bus after the final data phase.

The address phase and the data phase overlap as on a pipelined AHB bus. While beat k is in its data phase, beat k+1 is already on the address lines. The beat counter sits inside the block, so the client supplies only the first address and the first write value. Read data returns on a separate output with a one-cycle strobe per beat.

Top module: `ahb_burst_master`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, bus_req and data_out_valid are 0, htrans is 00 and hburst is 111.
- R2: Command codes are decoded as follows: 001 single write, 010 single read, 011 incrementing burst write, 100 incrementing burst read. Codes 000, 101, 110 and 111 start nothing: busy stays 0.
- R3: One cycle after a valid code is presented in idle, busy and bus_req are both 1. htrans stays 00 until the block has seen bus_grant and hready high together on a clock edge.
- R4: The first beat is driven with htrans 10 at the start address. hwrite is 1 for write commands and 0 for read commands. The htrans code 01 is never driven.
- R5: Each later beat of a burst is driven with htrans 11, and its address is one greater than the previous beat's address, wrapping at the address width.
- R6: For bursts, len_sel 000 gives 4 beats, 001 gives 8 and 010 gives 16. Any other len_sel gives 4 beats. hburst carries 000, 001 or 010 to match, and single transfers carry 111 and one beat.
- R7: While an address phase is pending and hready is low, haddr, htrans and hwrite hold their values.
- R8: In the data phase of write beat k (counting from 0), hwdata equals wr_data + k, modulo 2^DW.
- R9: For a read beat, data_out holds the value of hrdata from the clock edge where that beat's data phase completed. data_out_valid is 1 for exactly the cycle after that edge. It never pulses for writes or without a completed read data phase.
- R10: On the edge that completes the last data phase, busy and bus_req drop together. From the edge that accepted the last address until then, htrans is 00.
- R11: A command code presented while busy is 1 is ignored: the running transfer is unchanged and no new transfer starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_code | input | 3 | Command code from the local client |
| start_addr | input | AW | Address of the first beat |
| wr_data | input | DW | Write value of beat 0 |
| len_sel | input | 3 | Burst length selector |
| busy | output | 1 | High from command acceptance until bus release |
| bus_req | output | 1 | Request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| haddr | output | AW | Address phase address |
| htrans | output | 2 | Transfer type: 00 none, 10 first, 11 sequential |
| hwrite | output | 1 | 1 write, 0 read |
| hburst | output | 3 | Burst length code, 111 for single |
| hwdata | output | DW | Write data during the data phase |
| hrdata | input | DW | Read data from the slave |
| hready | input | 1 | Transfer completion from the slave |
| data_out | output | DW | Captured read data |
| data_out_valid | output | 1 | One-cycle strobe for data_out |

## Verification
The interesting overlap is an edge where the data phase of beat k completes while the address of beat k+1 is accepted. On that edge the block must capture read data or retire write data and advance the address in the same step. A further overlap occurs when a new command code arrives on the same edge that retires the last beat. The bench provokes both with random HREADY stalls and with command noise driven on every busy cycle. A slave model tracks the address and data phases separately from the sampled bus, and judges each beat's address, transfer type, write value and returned read data against per-beat values computed from the start address and the base value.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_XFER  = 2'd2,
    ST_DRAIN = 2'd3
  } ahbm_state_e;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  localparam logic [2:0] CMD_WR  = 3'b001;
  localparam logic [2:0] CMD_RD  = 3'b010;
  localparam logic [2:0] CMD_BWR = 3'b011;
  localparam logic [2:0] CMD_BRD = 3'b100;

  localparam logic [2:0] BL_4      = 3'b000;
  localparam logic [2:0] BL_8      = 3'b001;
  localparam logic [2:0] BL_16     = 3'b010;
  localparam logic [2:0] BL_SINGLE = 3'b111;

endpackage

// File: rtl/ahbm_cmd_decode.sv
module ahbm_cmd_decode
  import ahbm_pkg::*;
(
  input  logic [2:0] code,
  output logic       accept,
  output logic       is_write,
  output logic       is_burst
);
  always_comb begin
    accept   = 1'b0;
    is_write = 1'b0;
    is_burst = 1'b0;
    case (code)
      CMD_WR:  begin accept = 1'b1; is_write = 1'b1; end
      CMD_RD:  begin accept = 1'b1; end
      CMD_BWR: begin accept = 1'b1; is_write = 1'b1; is_burst = 1'b1; end
      CMD_BRD: begin accept = 1'b1; is_burst = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ahbm_len_map.sv
module ahbm_len_map
  import ahbm_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          is_burst,
  input  logic [2:0]    len_sel,
  output logic [CW-1:0] last_idx,
  output logic [2:0]    burst_code
);
  always_comb begin
    if (!is_burst) begin
      last_idx   = '0;
      burst_code = BL_SINGLE;
    end else begin
      case (len_sel)
        BL_8:    begin last_idx = CW'(7);  burst_code = BL_8;  end
        BL_16:   begin last_idx = CW'(15); burst_code = BL_16; end
        default: begin last_idx = CW'(3);  burst_code = BL_4;  end
      endcase
    end
  end
endmodule

// File: rtl/ahbm_beat_ctr.sv
module ahbm_beat_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master
  import ahbm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 8,
  parameter int MAX_BEATS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    ctrl_code,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    len_sel,
  output logic          busy,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  output logic [DW-1:0] data_out,
  output logic          data_out_valid
);
  localparam int CW = $clog2(MAX_BEATS);

  ahbm_state_e   state;
  logic          cmd_accept, cmd_write, cmd_burst;
  logic [CW-1:0] map_last, last_q, beat_idx;
  logic [2:0]    map_code, burst_q;
  logic [AW-1:0] base_addr;
  logic [DW-1:0] base_data;
  logic          op_write, dph_valid, dph_write;
  logic          ctr_clear, ctr_step, is_last;

  ahbm_cmd_decode u_dec (
    .code(ctrl_code), .accept(cmd_accept), .is_write(cmd_write), .is_burst(cmd_burst)
  );

  ahbm_len_map #(.CW(CW)) u_len (
    .is_burst(cmd_burst), .len_sel(len_sel), .last_idx(map_last), .burst_code(map_code)
  );

  assign is_last   = (beat_idx == last_q);
  assign ctr_clear = (state == ST_IDLE) && cmd_accept;
  assign ctr_step  = (state == ST_XFER) && hready && !is_last;

  ahbm_beat_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .clear(ctr_clear), .step(ctr_step), .cnt(beat_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      busy           <= 1'b0;
      bus_req        <= 1'b0;
      haddr          <= '0;
      htrans         <= TR_IDLE;
      hwrite         <= 1'b0;
      hburst         <= BL_SINGLE;
      hwdata         <= '0;
      data_out       <= '0;
      data_out_valid <= 1'b0;
      base_addr      <= '0;
      base_data      <= '0;
      op_write       <= 1'b0;
      last_q         <= '0;
      burst_q        <= BL_SINGLE;
      dph_valid      <= 1'b0;
      dph_write      <= 1'b0;
    end else begin
      data_out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_accept) begin
            busy      <= 1'b1;
            bus_req   <= 1'b1;
            base_addr <= start_addr;
            base_data <= wr_data;
            op_write  <= cmd_write;
            last_q    <= map_last;
            burst_q   <= map_code;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bus_grant && hready) begin
            haddr  <= base_addr;
            htrans <= TR_NSEQ;
            hwrite <= op_write;
            hburst <= burst_q;
            state  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (hready) begin
            dph_valid <= 1'b1;
            dph_write <= hwrite;
            if (hwrite) hwdata <= base_data + DW'(beat_idx);
            if (dph_valid && !dph_write) begin
              data_out       <= hrdata;
              data_out_valid <= 1'b1;
            end
            if (is_last) begin
              htrans <= TR_IDLE;
              state  <= ST_DRAIN;
            end else begin
              htrans <= TR_SEQ;
              haddr  <= haddr + 1'b1;
            end
          end
        end
        default: begin
          if (hready) begin
            if (!dph_write) begin
              data_out       <= hrdata;
              data_out_valid <= 1'b1;
            end
            dph_valid <= 1'b0;
            busy      <= 1'b0;
            bus_req   <= 1'b0;
            hburst    <= BL_SINGLE;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ahbm_checker.sv
module ahbm_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          bus_req,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic          hwrite,
  input logic          hready,
  input logic          data_out_valid
);
  // R3: an address phase only while the bus is requested
  assert_xfer_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    (htrans != 2'b00) |-> (bus_req && busy));

  // R4: the BUSY transfer type is never used
  assert_no_busy_type_R4: assert property (@(posedge clk) disable iff (rst)
    htrans != 2'b01);

  // R4: a sequential beat never directly follows an idle cycle
  assert_seq_after_start_R4: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b00) |=> (htrans != 2'b11));

  // R5: sequential beats step the address by one
  assert_seq_step_R5: assert property (@(posedge clk) disable iff (rst)
    (htrans != 2'b00 && hready) |=> (htrans != 2'b11 || haddr == $past(haddr) + 1'b1));

  // R7: a stalled address phase holds
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (htrans != 2'b00 && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)));

  // R9: read strobe only after a completing edge
  assert_strobe_after_ready_R9: assert property (@(posedge clk) disable iff (rst)
    data_out_valid |-> $past(hready));

  // R10: release leaves the bus idle
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!bus_req && htrans == 2'b00));
endmodule

bind ahb_burst_master ahbm_checker #(.AW(AW)) i_ahbm_checker (
  .clk(clk), .rst(rst), .busy(busy), .bus_req(bus_req), .haddr(haddr),
  .htrans(htrans), .hwrite(hwrite), .hready(hready), .data_out_valid(data_out_valid)
);

// File: tb/test_ahb_burst_master.sv
`timescale 1ns/1ps
module test_ahb_burst_master;
  localparam int AW = 32;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    ctrl_code;
  logic [AW-1:0] start_addr;
  logic [DW-1:0] wr_data;
  logic [2:0]    len_sel;
  logic          busy, bus_req, bus_grant;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          hwrite;
  logic [2:0]    hburst;
  logic [DW-1:0] hwdata, hrdata, data_out;
  logic          hready, data_out_valid;

  always #2.5 clk = ~clk;

  ahb_burst_master #(.AW(AW), .DW(DW)) i_ahb_burst_master (
    .clk(clk), .rst(rst), .ctrl_code(ctrl_code), .start_addr(start_addr),
    .wr_data(wr_data), .len_sel(len_sel), .busy(busy), .bus_req(bus_req),
    .bus_grant(bus_grant), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .data_out(data_out), .data_out_valid(data_out_valid)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // slave and expectation model
  bit            dph_pend = 0, dph_wr = 0, exp_dv = 0, grant_given = 0;
  logic [AW-1:0] dph_addr = '0, exp_start = '0, prev_haddr = '0;
  logic [DW-1:0] exp_do = '0, exp_base = '0;
  logic [1:0]    prev_htrans = '0;
  logic [2:0]    exp_hb = 3'b111;
  bit            prev_hready = 1, exp_wr = 0;
  int            dph_beat = 0, beat = 0, exp_total = 0, done_phases = 0, gwait = 0;

  function automatic logic [DW-1:0] rd_model(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int beats_of(logic [2:0] code, logic [2:0] sel);
    if (code != 3'd3 && code != 3'd4) return 1;
    if (sel == 3'd1) return 8;
    if (sel == 3'd2) return 16;
    return 4;
  endfunction

  function automatic logic [2:0] hb_of(logic [2:0] code, logic [2:0] sel);
    if (code != 3'd3 && code != 3'd4) return 3'b111;
    if (sel == 3'd1 || sel == 3'd2) return sel;
    return 3'b000;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (exp_dv)
      chk(data_out_valid && data_out == exp_do, "R9", "read capture",
          {data_out_valid, data_out}, {1'b1, exp_do});
    else if (data_out_valid)
      chk(1'b0, "R9", "unexpected strobe", 1, 0);
    exp_dv = 0;
    if (prev_htrans != 2'b00 && !prev_hready)
      chk(haddr == prev_haddr && htrans == prev_htrans, "R7", "stall hold",
          {htrans, haddr}, {prev_htrans, prev_haddr});
    if (htrans != 2'b00 && !grant_given)
      chk(1'b0, "R3", "address phase before grant", htrans, 0);
    if (!busy && !bus_req) grant_given = 0;
    hready = ($urandom % 4) != 0;
    hrdata = dph_pend ? rd_model(dph_addr) : DW'($urandom);
    if (hready && dph_pend) begin
      if (dph_wr)
        chk(hwdata == DW'(exp_base + DW'(dph_beat)), "R8", "write beat data",
            hwdata, DW'(exp_base + DW'(dph_beat)));
      else begin
        exp_dv = 1;
        exp_do = hrdata;
      end
      dph_pend = 0;
      done_phases++;
    end
    if (hready && htrans[1]) begin
      chk(haddr == exp_start + AW'(beat), "R5", "beat address", haddr, exp_start + AW'(beat));
      if (beat == 0) chk(htrans == 2'b10, "R4", "first beat type", htrans, 2'b10);
      else           chk(htrans == 2'b11, "R5", "later beat type", htrans, 2'b11);
      chk(hwrite == exp_wr, "R4", "direction", hwrite, exp_wr);
      chk(hburst == exp_hb, "R6", "length code", hburst, exp_hb);
      dph_pend = 1; dph_wr = exp_wr; dph_addr = haddr; dph_beat = beat;
      beat++;
    end
    if (bus_req) begin
      if (gwait > 0) begin gwait--; bus_grant = 0; end
      else bus_grant = 1;
    end else bus_grant = 0;
    if (bus_grant && hready) grant_given = 1;
    prev_htrans = htrans; prev_haddr = haddr; prev_hready = hready;
  endtask

  task automatic run_cmd(logic [2:0] code, logic [AW-1:0] a, logic [DW-1:0] d, logic [2:0] sel);
    bit valid;
    valid = (code >= 3'd1 && code <= 3'd4);
    tick();
    ctrl_code = code; start_addr = a; wr_data = d; len_sel = sel;
    exp_start = a; exp_base = d; exp_wr = (code == 3'd1 || code == 3'd3);
    exp_total = beats_of(code, sel); exp_hb = hb_of(code, sel);
    beat = 0; done_phases = 0; gwait = $urandom % 4;
    tick();
    ctrl_code = 3'd0;
    if (!valid) begin
      chk(!busy && !bus_req, "R2", "idle code starts nothing", {busy, bus_req}, 0);
      return;
    end
    chk(busy && bus_req, "R3", "request after command", {busy, bus_req}, 2'b11);
    for (int i = 0; i < 400; i++) begin
      tick();
      if (!busy) break;
      if ($urandom % 3 == 0) begin
        ctrl_code = 3'(1 + $urandom % 4); start_addr = $urandom;
        wr_data = DW'($urandom); len_sel = 3'($urandom % 3);
      end else ctrl_code = 3'd0;
    end
    chk(!bus_req && htrans == 2'b00, "R10", "release", {bus_req, htrans}, 0);
    chk(beat == exp_total && done_phases == exp_total && !dph_pend, "R6", "beat count",
        beat, exp_total);
    ctrl_code = 3'd0;
    tick();
    chk(!busy, "R11", "no command taken while busy", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1; ctrl_code = 0; start_addr = 0; wr_data = 0; len_sel = 0;
    hready = 1; bus_grant = 0; hrdata = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && htrans == 2'b00 && !data_out_valid && hburst == 3'b111,
        "R1", "reset state", {busy, bus_req, htrans, data_out_valid, hburst}, 7'b0000111);
    rst = 0;
    @(negedge clk);
    chk(!busy && !bus_req && htrans == 2'b00, "R1", "after reset", {busy, bus_req, htrans}, 0);
    // directed cases
    run_cmd(3'd1, 32'h0000_1000, 8'h11, 3'd0);
    run_cmd(3'd2, 32'h0000_2345, 8'h00, 3'd0);
    run_cmd(3'd3, 32'h0000_0100, 8'hF0, 3'd0);
    run_cmd(3'd4, 32'h0000_0200, 8'h00, 3'd1);
    run_cmd(3'd3, 32'h0000_0300, 8'hFA, 3'd2);
    run_cmd(3'd4, 32'h0000_0400, 8'h00, 3'd2);
    run_cmd(3'd0, 32'h0, 8'h0, 3'd0);
    run_cmd(3'd5, 32'h0, 8'h0, 3'd0);
    run_cmd(3'd6, 32'h0, 8'h0, 3'd1);
    run_cmd(3'd7, 32'h0, 8'h0, 3'd2);
    run_cmd(3'd3, 32'h0000_0500, 8'h20, 3'd6);
    run_cmd(3'd4, 32'hFFFF_FFFE, 8'h00, 3'd0);
    // random mix
    for (int k = 0; k < 40; k++)
      run_cmd(3'($urandom % 8), $urandom, DW'($urandom), 3'($urandom % 8));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule